// File: doc/BRIEF.md
# I2C Master Bus-Condition Sequencer

This block lets software take and give back an I2C bus as master without handling the line timing itself. Software writes a four-bit control word; certain combinations of those bits are commands that make the block form a stop condition, let go of the bus before a repeated start, or form a start condition. The block drives the open-drain SCL and SDA wires through active-high pull-low enables. It samples both wires through synchronizers and reports a bus-busy flag, a pending flag, the sampled SCL level and a bus-free indication.

During a stop, the busy flag drops as soon as the block lets its own SCL go high. It does not wait for the stop to appear on the wires. Software that needs to know the bus is truly free therefore uses the bus-free output, which is high only when both sampled wires are high. Before a start, the block waits for a programmable number of consecutive bus-free cycles. This wait covers the setup time that a repeated start needs.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset the control bits master, transmit, busy and pending all read 0, and neither wire is pulled low.
- R2: A control write puts master in bit 3, transmit in bit 2, busy in bit 1 and pending in bit 0. A write that is not a command copies master and transmit, clears pending when bit 0 is 0, and never changes busy.
- R3: Writing 1101 while busy is 1 forms a stop. SCL is released while SDA is held low, and SDA is released only after SCL is seen high for a hold interval. At the end, pending reads 1 and both wires are released.
- R4: During a stop, busy reads 0 from the cycle the block releases SCL. This holds even while another device keeps SCL low, and SDA stays pulled low until SCL is sensed high.
- R5: The last-received-bit status equals the synchronized SCL level, and bus-free is high only when both synchronized wires are high.
- R6: Writing 0001 while busy is 1 clears master and transmit and releases SDA first, then SCL, without forming a stop. Busy clears when SCL is released. Pending sets once SCL is sensed high.
- R7: Writing 1111 while busy is 0 waits until bus-free has been high for setup_cycles+1 consecutive cycles, restarting the count on any low. It then pulls SDA low with SCL released, then pulls SCL low. Busy sets when SDA is pulled low, and pending sets when the sequence ends.
- R8: Control writes made while a stop, release or start sequence is running are ignored.
- R9: The stop or release pattern written while busy is 0, and the start pattern written while busy is 1, act as plain writes (R2).
- R10: A command write clears pending in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control write strobe |
| reg_wdata | input | 4 | Control word {master, transmit, busy, pending} |
| setup_cycles | input | SETUP_W | Bus-free cycles, minus one, required before a start |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| stat_mst | output | 1 | Master bit |
| stat_trx | output | 1 | Transmit bit |
| stat_bb | output | 1 | Bus busy |
| stat_pin | output | 1 | Pending flag |
| stat_lrb | output | 1 | Synchronized SCL level |
| bus_free | output | 1 | Both synchronized wires high |

## Verification
The bench holds SCL low from outside during a stop. A design that waited for the wire before clearing busy would keep busy at 1 there, and one that released SDA early would form a false stop. It writes a zero word during that stall; a design that took it would lose the master bit. It measures the exact cycle count from a start write to the SDA pull, both on an idle bus and after an outside SCL hold. A counter that did not restart, or that was off by one, shows up as a wrong count. It also writes the command patterns against the wrong busy state, which a loose decoder would turn into spurious sequences.

// File: rtl/i2c_cond_seq_pkg.sv
package i2c_cond_seq_pkg;

   localparam int CTL_W = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HOLD,
      ST_STP_A,
      ST_STP_B,
      ST_STP_C,
      ST_REL_A,
      ST_REL_B,
      ST_SETUP,
      ST_STA_A,
      ST_STA_B
   } seq_state_e;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_STOP,
      CMD_RELEASE,
      CMD_START
   } seq_cmd_e;

   typedef struct packed {
      logic mst;
      logic trx;
      logic bb;
      logic pin;
   } ctl_bits_t;

endpackage

// File: rtl/i2c_cond_seq_sync.sv
module i2c_cond_seq_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad
      $error("i2c_cond_seq_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= RESET_VAL;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= {STAGES{RESET_VAL}};
         else        sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/i2c_cond_seq_decode.sv
module i2c_cond_seq_decode
   import i2c_cond_seq_pkg::*;
(
   input  ctl_bits_t wr_bits,
   input  logic      cur_bb,
   output seq_cmd_e  cmd
);

   always_comb begin
      cmd = CMD_NONE;
      if (cur_bb && wr_bits.mst && wr_bits.trx && !wr_bits.bb && wr_bits.pin)
         cmd = CMD_STOP;
      else if (cur_bb && !wr_bits.mst && !wr_bits.trx && !wr_bits.bb && wr_bits.pin)
         cmd = CMD_RELEASE;
      else if (!cur_bb && wr_bits.mst && wr_bits.trx && wr_bits.bb && wr_bits.pin)
         cmd = CMD_START;
   end

endmodule

// File: rtl/i2c_cond_seq_fsm.sv
module i2c_cond_seq_fsm
   import i2c_cond_seq_pkg::*;
#(
   parameter int PHASE_CYC = 4,
   parameter int SETUP_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_mst,
   input  logic               wr_trx,
   input  logic               wr_pin,
   input  seq_cmd_e           cmd,
   input  logic [SETUP_W-1:0] setup_cycles,
   input  logic               scl_s,
   input  logic               sda_s,
   output ctl_bits_t          ctl,
   output logic               scl_oe,
   output logic               sda_oe
);

   localparam int PH_W = (PHASE_CYC < 2) ? 1 : $clog2(PHASE_CYC);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASE_CYC - 1);

   seq_state_e         st;
   logic [PH_W-1:0]    ph;
   logic [SETUP_W-1:0] cnt;
   logic               accept;
   logic               ph_last;
   logic               lines_free;

   assign accept     = wr_en && ((st == ST_IDLE) || (st == ST_HOLD));
   assign ph_last    = (ph == PH_LAST);
   assign lines_free = scl_s && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         ph  <= '0;
         cnt <= '0;
         ctl <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_HOLD: begin
               if (accept) begin
                  case (cmd)
                     CMD_STOP: begin
                        st      <= ST_STP_A;
                        ph      <= '0;
                        ctl.mst <= 1'b1;
                        ctl.trx <= 1'b1;
                        ctl.pin <= 1'b0;
                     end
                     CMD_RELEASE: begin
                        st      <= ST_REL_A;
                        ph      <= '0;
                        ctl.mst <= 1'b0;
                        ctl.trx <= 1'b0;
                        ctl.pin <= 1'b0;
                     end
                     CMD_START: begin
                        st      <= ST_SETUP;
                        cnt     <= '0;
                        ctl.mst <= 1'b1;
                        ctl.trx <= 1'b1;
                        ctl.pin <= 1'b0;
                     end
                     default: begin
                        ctl.mst <= wr_mst;
                        ctl.trx <= wr_trx;
                        ctl.pin <= ctl.pin & wr_pin;
                     end
                  endcase
               end
            end
            ST_STP_A: begin
               if (ph_last) begin
                  st     <= ST_STP_B;
                  ph     <= '0;
                  ctl.bb <= 1'b0;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_STP_B: begin
               if (!scl_s)       ph <= '0;
               else if (ph_last) begin
                  st <= ST_STP_C;
                  ph <= '0;
               end else          ph <= ph + 1'b1;
            end
            ST_STP_C: begin
               if (sda_s) begin
                  st      <= ST_IDLE;
                  ctl.pin <= 1'b1;
               end
            end
            ST_REL_A: begin
               if (ph_last) begin
                  st     <= ST_REL_B;
                  ph     <= '0;
                  ctl.bb <= 1'b0;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_REL_B: begin
               if (scl_s) begin
                  st      <= ST_IDLE;
                  ctl.pin <= 1'b1;
               end
            end
            ST_SETUP: begin
               if (!lines_free)              cnt <= '0;
               else if (cnt == setup_cycles) begin
                  st     <= ST_STA_A;
                  ph     <= '0;
                  ctl.bb <= 1'b1;
               end else                      cnt <= cnt + 1'b1;
            end
            ST_STA_A: begin
               if (ph_last) begin
                  st <= ST_STA_B;
                  ph <= '0;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_STA_B: begin
               if (ph_last) begin
                  st      <= ST_HOLD;
                  ctl.pin <= 1'b1;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      case (st)
         ST_HOLD, ST_STP_A, ST_STA_B: begin
            scl_oe = 1'b1;
            sda_oe = 1'b1;
         end
         ST_STP_B, ST_STA_A: sda_oe = 1'b1;
         ST_REL_A:           scl_oe = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
   import i2c_cond_seq_pkg::*;
#(
   parameter int PHASE_CYC   = 4,
   parameter int SETUP_W     = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [3:0]         reg_wdata,
   input  logic [SETUP_W-1:0] setup_cycles,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               scl_oe,
   output logic               sda_oe,
   output logic               stat_mst,
   output logic               stat_trx,
   output logic               stat_bb,
   output logic               stat_pin,
   output logic               stat_lrb,
   output logic               bus_free
);

   if (PHASE_CYC < 2) begin : g_bad_phase
      $error("i2c_cond_seq: PHASE_CYC must be at least 2");
   end
   if (SETUP_W < 1) begin : g_bad_setup
      $error("i2c_cond_seq: SETUP_W must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("i2c_cond_seq: SYNC_STAGES must be at least 1");
   end

   ctl_bits_t wr_bits;
   ctl_bits_t ctl;
   seq_cmd_e  cmd;
   logic      scl_s;
   logic      sda_s;

   assign wr_bits = ctl_bits_t'(reg_wdata);

   i2c_cond_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
   );

   i2c_cond_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   i2c_cond_seq_decode u_decode (
      .wr_bits(wr_bits),
      .cur_bb (ctl.bb),
      .cmd    (cmd)
   );

   i2c_cond_seq_fsm #(.PHASE_CYC(PHASE_CYC), .SETUP_W(SETUP_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_we),
      .wr_mst      (wr_bits.mst),
      .wr_trx      (wr_bits.trx),
      .wr_pin      (wr_bits.pin),
      .cmd         (cmd),
      .setup_cycles(setup_cycles),
      .scl_s       (scl_s),
      .sda_s       (sda_s),
      .ctl         (ctl),
      .scl_oe      (scl_oe),
      .sda_oe      (sda_oe)
   );

   assign stat_mst = ctl.mst;
   assign stat_trx = ctl.trx;
   assign stat_bb  = ctl.bb;
   assign stat_pin = ctl.pin;
   assign stat_lrb = scl_s;
   assign bus_free = scl_s & sda_s;

endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk #(
   parameter int SETUP_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               scl_oe,
   input logic               sda_oe,
   input logic               stat_mst,
   input logic               stat_bb,
   input logic               stat_pin,
   input logic               bus_free,
   input logic [SETUP_W-1:0] setup_cycles
);

   logic [SETUP_W:0] free_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 free_run <= '0;
      else if (!bus_free)         free_run <= '0;
      else if (free_run != '1)    free_run <= free_run + 1'b1;
   end

   // R7: SDA is pulled only while SCL is released (start edge)
   p_sda_pull_scl_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_oe);

   // R7: SCL is pulled only after SDA is already low
   p_scl_after_sda_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> sda_oe);

   // R7: the start edge follows enough bus-free cycles
   p_setup_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> (free_run >= {1'b0, setup_cycles}));

   // R3: as master, SDA is let go only while SCL is released
   p_stop_sda_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_oe) && stat_mst) |-> !scl_oe);

   // R4: busy drops in the cycle the block lets SCL go
   p_bb_drop_scl_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_bb) |-> !scl_oe);

   // R6: a finished stop or release leaves both wires undriven
   p_done_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat_pin) && !stat_bb) |-> (!scl_oe && !sda_oe));

endmodule

bind i2c_cond_seq i2c_cond_seq_chk #(.SETUP_W(SETUP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_oe      (scl_oe),
   .sda_oe      (sda_oe),
   .stat_mst    (stat_mst),
   .stat_bb     (stat_bb),
   .stat_pin    (stat_pin),
   .bus_free    (bus_free),
   .setup_cycles(setup_cycles)
);

// File: tb/i2c_cond_seq_bench.sv
module i2c_cond_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SETUP_W    = 10;
   localparam int SETUP_VAL  = 20;
   localparam int NVEC       = 11;

   // {is_cmd, wdata[3:0], exp mst trx bb pin, exp scl_oe sda_oe}
   localparam logic [10:0] VEC [NVEC] = '{
      11'b1_1111_1111_11,   // start from idle
      11'b0_1110_1110_11,   // clear pending
      11'b0_0110_0110_11,   // plain write of master bit
      11'b1_1101_1101_00,   // stop
      11'b0_1100_1100_00,   // clear pending
      11'b0_1101_1100_00,   // stop pattern with busy 0: plain
      11'b1_1111_1111_11,   // start
      11'b0_1111_1111_11,   // start pattern with busy 1: plain
      11'b1_0001_0001_00,   // release for restart
      11'b1_1111_1111_11,   // start
      11'b1_1101_1101_00    // stop
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_we = 1'b0;
   logic [3:0]         reg_wdata = '0;
   logic [SETUP_W-1:0] setup_cycles = SETUP_W'(SETUP_VAL);
   logic               ext_scl_low = 1'b0;
   logic               scl_in, sda_in;
   logic               scl_oe, sda_oe;
   logic               stat_mst, stat_trx, stat_bb, stat_pin, stat_lrb, bus_free;

   int total = 0;
   int bad   = 0;

   assign scl_in = !(scl_oe || ext_scl_low);
   assign sda_in = !sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_cond_seq #(.SETUP_W(SETUP_W)) u_i2c_cond_seq (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .setup_cycles(setup_cycles), .scl_in(scl_in), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .stat_mst(stat_mst), .stat_trx(stat_trx),
      .stat_bb(stat_bb), .stat_pin(stat_pin), .stat_lrb(stat_lrb), .bus_free(bus_free)
   );

   task automatic check(input string tag, input int actual, input int expected);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
      end
   endtask

   task automatic write_reg(input logic [3:0] w);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_wdata = w;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic wait_pin();
      for (int i = 0; i < 3000; i++) begin
         if (stat_pin) break;
         @(negedge clk);
      end
   endtask

   function automatic int ctl4();
      return {28'd0, stat_mst, stat_trx, stat_bb, stat_pin};
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ctl bits", ctl4(), 0);
      check("R1 oe", {scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R5 bus free after reset", bus_free, 1);
      check("R5 lrb after reset", stat_lrb, 1);

      // table walk: R2 R3 R6 R7 R9
      for (int k = 0; k < NVEC; k++) begin
         write_reg(VEC[k][9:6]);
         if (VEC[k][10]) wait_pin();
         repeat (3) @(negedge clk);
         check($sformatf("R2/R3/R6/R7/R9 step %0d ctl", k), ctl4(), int'(VEC[k][5:2]));
         check($sformatf("R2/R3/R6/R7/R9 step %0d oe", k), {scl_oe, sda_oe}, int'(VEC[k][1:0]));
      end

      // R7 exact setup wait on an idle bus; R10 pending cleared by command
      write_reg(4'b1111);
      check("R10 pending cleared", stat_pin, 0);
      n = 0;
      while (!sda_oe && n < 1000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      check("R7 setup cycles idle", n, SETUP_VAL + 1);
      check("R7 scl free at sda pull", scl_oe, 0);
      check("R7 busy at sda pull", stat_bb, 1);
      wait_pin();
      check("R7 start done oe", {scl_oe, sda_oe}, 3);

      // R4 early busy clear with SCL held by another device; R8 ignore
      write_reg(4'b1101);
      ext_scl_low = 1'b1;
      repeat (30) @(negedge clk);
      check("R4 busy cleared early", stat_bb, 0);
      check("R4 sda still pulled", sda_oe, 1);
      check("R5 bus not free", bus_free, 0);
      check("R5 lrb low", stat_lrb, 0);
      write_reg(4'b0000);
      repeat (3) @(negedge clk);
      check("R8 write ignored mst/trx", {stat_mst, stat_trx}, 3);
      ext_scl_low = 1'b0;
      wait_pin();
      repeat (2) @(negedge clk);
      check("R3 stop done ctl", ctl4(), 4'b1101);
      check("R3 stop done oe", {scl_oe, sda_oe}, 0);
      check("R5 bus free after stop", bus_free, 1);

      // R7 start held off while SCL is low elsewhere, count restarts
      ext_scl_low = 1'b1;
      repeat (3) @(negedge clk);
      write_reg(4'b1111);
      repeat (60) @(negedge clk);
      check("R7 no start while scl low", sda_oe, 0);
      check("R7 busy stays 0", stat_bb, 0);
      check("R5 lrb shows scl low", stat_lrb, 0);
      ext_scl_low = 1'b0;
      n = 0;
      while (!sda_oe && n < 1000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      check("R7 setup after scl release", n, SETUP_VAL + 3);
      wait_pin();

      // R6 release ordering
      write_reg(4'b0001);
      check("R6 sda released first", {scl_oe, sda_oe}, 2);
      check("R6 mst trx cleared", {stat_mst, stat_trx}, 0);
      wait_pin();
      repeat (2) @(negedge clk);
      check("R6 busy clear after release", stat_bb, 0);
      check("R6 lrb high after release", stat_lrb, 1);
      check("R6 lines released", {scl_oe, sda_oe}, 0);

      // R9 release pattern with busy 0 acts as plain write
      write_reg(4'b0000);
      write_reg(4'b0001);
      repeat (3) @(negedge clk);
      check("R9 release pattern idle", ctl4(), 0);
      check("R9 no drive", {scl_oe, sda_oe}, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule